// File: doc/BRIEF.md
# Maskable Interrupt Controller with Software Posting

This block sits between a set of peripherals and a CPU core. Each peripheral delivers single-cycle event pulses. The block keeps a posted flag for every source. Each flag is gated by a per-source enable bit, and the gated result becomes a pending request. A fixed-priority encoder turns the pending requests into one request line and the number of the winning source. When the CPU takes the interrupt, it returns an acknowledge pulse carrying that number, and the matching flag is dropped.

Software reaches the block over a byte-wide register bus with a combinational read path. There are three status/clear registers, one bit per source. There are three enable registers on the same layout, plus a control register that holds the software-post enable bit. That bit decides what a write to a status/clear register means. With the bit low, a write clears the flags where the written bit is 0. With the bit high, a write raises the flags where the written bit is 1. Software can therefore raise any interrupt without hardware activity, which is useful when debugging service routines.

Top module: `evt_irq_ctrl`

## Requirements
- R1: Status/clear registers sit at addresses 0xDA, 0xDB and 0xDC. Bit j of the register at 0xDA+k reports source 8k+j: it reads 1 while that source has a posted flag and 0 otherwise.
- R2: An event pulse on a source sets that source's posted flag from the next cycle, whatever the state of its enable bit.
- R3: The request output is high exactly when at least one source has both its posted flag and its enable bit at 1. A posted source whose enable bit is 0 never drives the request.
- R4: Enable registers at 0xE0, 0xE1 and 0xE2 hold one bit per source, using the same bit mapping as R1, and read back what was written. The control register at 0xE3 holds the software-post enable in bit 7; its bits 6..0 always read 0. Each enable bit is independent of all the others.
- R5: With the software-post enable at 0, writing a status/clear register clears each flag whose written bit is 0 and leaves alone each flag whose written bit is 1.
- R6: With the software-post enable at 1, writing a status/clear register sets each flag whose written bit is 1 and ignores each written 0.
- R7: When an event pulse and a clear (by register write or by acknowledge) hit the same source in the same cycle, the flag ends up set.
- R8: The vector output carries the lowest-numbered pending source as a 5-bit binary number.
- R9: An acknowledge pulse clears only the flag of the source named on the acknowledge vector input. The request and vector outputs reflect this from the next cycle.
- R10: Reset clears every posted flag, every enable bit and the software-post enable. Reads of any unmapped address return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Synchronous active-low reset |
| evt_i | input | 24 | One-cycle event pulses, bit n for source n |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address for read and write |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Combinational read data for reg_addr_i |
| ack_i | input | 1 | Interrupt acknowledge pulse from the CPU |
| ack_vec_i | input | 5 | Source number being acknowledged |
| irq_req_o | output | 1 | Interrupt request |
| irq_vec_o | output | 5 | Number of the highest-priority pending source |

## Verification
Every state change (an event, a register write or an acknowledge) is registered once. Its effect on the request, the vector and the read data is therefore due one clock edge after the stimulus. The read data also follows the address combinationally within the same cycle. The bench drives stimulus on the falling edge and steps its reference model once per rising edge. It compares all three outputs at the next falling edge, after that single register stage has settled. Same-cycle collisions of events with clears and acknowledges are applied on one edge, so the expected winner is judged on the very next comparison.

// File: rtl/evt_irq_pkg.sv
// Package: shared constants and types for the interrupt controller.
// Assumes an 8-bit register bus and at most three source groups.
package evt_irq_pkg;
    localparam int          REG_W     = 8;
    localparam logic [7:0]  STAT_BASE = 8'hDA;   // status/clear registers
    localparam logic [7:0]  ENA_BASE  = 8'hE0;   // enable registers
    localparam logic [7:0]  CTL_ADDR  = 8'hE3;   // control register
    localparam int          SWP_BIT   = 7;       // software-post enable bit

    typedef struct packed {
        logic             we;
        logic [7:0]       addr;
        logic [REG_W-1:0] data;
    } reg_wr_t;
endpackage

// File: rtl/evt_flag_bank.sv
// Module: one posted flag per source.
// Set by an event, by a software post or held; cleared by a software clear
// or by an acknowledge. An event always beats a clear in the same cycle.
// Assumes wr_sel_i/wr_bits_i are already decoded per source by the parent.
module evt_flag_bank #(
    parameter int N_SRC = 24,
    parameter int VEC_W = 5
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic [N_SRC-1:0] evt_i,
    input  logic [N_SRC-1:0] wr_sel_i,
    input  logic [N_SRC-1:0] wr_bits_i,
    input  logic             swp_en_i,
    input  logic             ack_i,
    input  logic [VEC_W-1:0] ack_vec_i,
    output logic [N_SRC-1:0] flags_o
);
    logic [N_SRC-1:0] flag_q;

    for (genvar i = 0; i < N_SRC; i++) begin : g_bit
        logic set_c, clr_c;

        // Decode the set and clear causes for this source.
        always_comb begin
            set_c = evt_i[i] | (wr_sel_i[i] & swp_en_i & wr_bits_i[i]);
            clr_c = (wr_sel_i[i] & ~swp_en_i & ~wr_bits_i[i])
                  | (ack_i & (ack_vec_i == VEC_W'(i)));
        end

        // Flag register: set wins over clear.
        always_ff @(posedge clk_i) begin
            if (!rst_n_i)      flag_q[i] <= 1'b0;
            else if (set_c)    flag_q[i] <= 1'b1;
            else if (clr_c)    flag_q[i] <= 1'b0;
        end

        assert_evt_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
            evt_i[i] |=> flag_q[i]);
        assert_swclr_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
            (wr_sel_i[i] && !swp_en_i && !wr_bits_i[i] && !evt_i[i]) |=> !flag_q[i]);
        assert_swpost_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
            (wr_sel_i[i] && swp_en_i && wr_bits_i[i]) |=> flag_q[i]);
        assert_ack_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
            (ack_i && ack_vec_i == VEC_W'(i) && !evt_i[i]
             && !(wr_sel_i[i] && swp_en_i && wr_bits_i[i])) |=> !flag_q[i]);
        assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
            (flag_q[i] && !wr_sel_i[i] && !(ack_i && ack_vec_i == VEC_W'(i))) |=> flag_q[i]);
    end

    assign flags_o = flag_q;
endmodule

// File: rtl/evt_ena_regs.sv
// Module: per-source enable registers and the control register.
// Holds one enable bit per source in byte-wide groups plus the
// software-post enable; gives a read value and a hit flag for its range.
// Assumes at most three groups so the control register does not collide.
module evt_ena_regs
    import evt_irq_pkg::*;
#(
    parameter int N_SRC = 24
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  reg_wr_t          wr_i,
    input  logic [7:0]       rd_addr_i,
    output logic [N_SRC-1:0] ena_o,
    output logic             swp_en_o,
    output logic [REG_W-1:0] rdata_o,
    output logic             hit_o
);
    localparam int N_GRP = (N_SRC + REG_W - 1) / REG_W;
    localparam int PAD_W = N_GRP * REG_W;

    logic [N_SRC-1:0] ena_q;
    logic             swp_q;
    logic [PAD_W-1:0] ena_pad;

    assign ena_pad = PAD_W'(ena_q);

    for (genvar i = 0; i < N_SRC; i++) begin : g_ena
        // Enable bit i captures its byte lane on a write to its group.
        always_ff @(posedge clk_i) begin
            if (!rst_n_i)
                ena_q[i] <= 1'b0;
            else if (wr_i.we && wr_i.addr == ENA_BASE + 8'(i / REG_W))
                ena_q[i] <= wr_i.data[i % REG_W];
        end
    end

    // Software-post enable lives in the control register.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)
            swp_q <= 1'b0;
        else if (wr_i.we && wr_i.addr == CTL_ADDR)
            swp_q <= wr_i.data[SWP_BIT];
    end

    // Read mux over the enable groups and the control register.
    always_comb begin
        rdata_o = '0;
        hit_o   = 1'b0;
        for (int g = 0; g < N_GRP; g++) begin
            if (rd_addr_i == ENA_BASE + 8'(g)) begin
                rdata_o = ena_pad[g*REG_W +: REG_W];
                hit_o   = 1'b1;
            end
        end
        if (rd_addr_i == CTL_ADDR) begin
            rdata_o          = '0;
            rdata_o[SWP_BIT] = swp_q;
            hit_o            = 1'b1;
        end
    end

    assign ena_o    = ena_q;
    assign swp_en_o = swp_q;

    assert_ctl_write_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (wr_i.we && wr_i.addr == CTL_ADDR) |=> (swp_en_o == $past(wr_i.data[SWP_BIT])));
    assert_ctl_low_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (rd_addr_i == CTL_ADDR) |-> (rdata_o[SWP_BIT-1:0] == '0));
endmodule

// File: rtl/evt_prio_enc.sv
// Module: fixed-priority encoder, lowest index wins.
// Purely combinational; assumes VEC_W bits can name every input.
module evt_prio_enc #(
    parameter int N     = 24,
    parameter int VEC_W = 5
) (
    input  logic [N-1:0]     pend_i,
    output logic             req_o,
    output logic [VEC_W-1:0] vec_o
);
    // Scan from the top so the lowest pending index is the final value.
    always_comb begin
        req_o = 1'b0;
        vec_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                req_o = 1'b1;
                vec_o = VEC_W'(i);
            end
        end
    end
endmodule

// File: rtl/evt_irq_ctrl.sv
// Module: top of the maskable interrupt controller.
// Decodes register writes to the status/clear registers, gates the posted
// flags with the enable bits and feeds the priority encoder.
// Assumes N_SRC <= 24 (three groups) and a combinational read path.
module evt_irq_ctrl
    import evt_irq_pkg::*;
#(
    parameter int N_SRC = 24,
    parameter int VEC_W = 5
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic [N_SRC-1:0] evt_i,
    input  logic             reg_we_i,
    input  logic [7:0]       reg_addr_i,
    input  logic [7:0]       reg_wdata_i,
    output logic [7:0]       reg_rdata_o,
    input  logic             ack_i,
    input  logic [VEC_W-1:0] ack_vec_i,
    output logic             irq_req_o,
    output logic [VEC_W-1:0] irq_vec_o
);
    localparam int N_GRP = (N_SRC + REG_W - 1) / REG_W;
    localparam int PAD_W = N_GRP * REG_W;

    reg_wr_t          wr;
    logic [N_SRC-1:0] wr_sel, wr_bits, flags, ena, pend;
    logic [PAD_W-1:0] flags_pad;
    logic             swp_en, ena_hit;
    logic [REG_W-1:0] ena_rdata;

    assign wr = '{we: reg_we_i, addr: reg_addr_i, data: reg_wdata_i};

    // Spread a status/clear write onto the sources of the addressed group.
    always_comb begin
        for (int i = 0; i < N_SRC; i++) begin
            wr_sel[i]  = wr.we && (wr.addr == STAT_BASE + 8'(i / REG_W));
            wr_bits[i] = wr.data[i % REG_W];
        end
    end

    evt_flag_bank #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_flags (
        .clk_i     (clk_i),
        .rst_n_i   (rst_n_i),
        .evt_i     (evt_i),
        .wr_sel_i  (wr_sel),
        .wr_bits_i (wr_bits),
        .swp_en_i  (swp_en),
        .ack_i     (ack_i),
        .ack_vec_i (ack_vec_i),
        .flags_o   (flags)
    );

    evt_ena_regs #(.N_SRC(N_SRC)) u_ena (
        .clk_i     (clk_i),
        .rst_n_i   (rst_n_i),
        .wr_i      (wr),
        .rd_addr_i (reg_addr_i),
        .ena_o     (ena),
        .swp_en_o  (swp_en),
        .rdata_o   (ena_rdata),
        .hit_o     (ena_hit)
    );

    assign pend = flags & ena;

    evt_prio_enc #(.N(N_SRC), .VEC_W(VEC_W)) u_enc (
        .pend_i (pend),
        .req_o  (irq_req_o),
        .vec_o  (irq_vec_o)
    );

    assign flags_pad = PAD_W'(flags);

    // Read mux: status groups, then the enable/control range.
    always_comb begin
        reg_rdata_o = '0;
        for (int g = 0; g < N_GRP; g++) begin
            if (reg_addr_i == STAT_BASE + 8'(g))
                reg_rdata_o = flags_pad[g*REG_W +: REG_W];
        end
        if (ena_hit)
            reg_rdata_o = ena_rdata;
    end

    assert_req_has_source_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        irq_req_o |-> (flags[irq_vec_o] && ena[irq_vec_o]));
    assert_idle_no_req_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ((flags & ena) == '0) |-> !irq_req_o);
    assert_lowest_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        irq_req_o |-> ((flags & ena & ((N_SRC'(1) << irq_vec_o) - N_SRC'(1))) == '0));
    assert_reset_clear_R10: assert property (@(posedge clk_i)
        !rst_n_i |=> (flags == '0 && ena == '0 && !swp_en));
endmodule

// File: tb/evt_irq_ctrl_tb_top.sv
// Bench: behavioural reference model stepped every clock and compared
// on every falling edge against request, vector and read data.
module evt_irq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] evt = '0;
    logic        we = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic        ack = 1'b0;
    logic [4:0]  ack_vec = '0;
    logic        req;
    logic [4:0]  vec;

    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc = 0;
    string tag = "R10";

    // Reference state.
    bit m_flag [24];
    bit m_ena  [24];
    bit m_swp;

    always #4 clk = ~clk;

    evt_irq_ctrl dut_i (
        .clk_i(clk), .rst_n_i(rst_n), .evt_i(evt), .reg_we_i(we),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .ack_i(ack), .ack_vec_i(ack_vec), .irq_req_o(req), .irq_vec_o(vec)
    );

    task automatic model_step();
        bit nf [24];
        bit old_swp = m_swp;
        if (!rst_n) begin
            for (int i = 0; i < 24; i++) begin m_flag[i] = 0; m_ena[i] = 0; end
            m_swp = 0;
            return;
        end
        for (int i = 0; i < 24; i++) begin
            nf[i] = m_flag[i];
            if (ack && int'(ack_vec) == i) nf[i] = 0;
            if (we && int'(addr) == 'hDA + i / 8) begin
                if (!old_swp && !wdata[i % 8]) nf[i] = 0;
                if (old_swp && wdata[i % 8]) nf[i] = 1;
            end
            if (evt[i]) nf[i] = 1;
        end
        for (int i = 0; i < 24; i++) begin
            m_flag[i] = nf[i];
            if (we && int'(addr) == 'hE0 + i / 8) m_ena[i] = wdata[i % 8];
        end
        if (we && addr == 8'hE3) m_swp = wdata[7];
    endtask

    function automatic logic [7:0] model_read(logic [7:0] a);
        logic [7:0] r = '0;
        for (int b = 0; b < 8; b++) begin
            if (a >= 8'hDA && a <= 8'hDC) r[b] = m_flag[(int'(a) - 'hDA) * 8 + b];
            if (a >= 8'hE0 && a <= 8'hE2) r[b] = m_ena[(int'(a) - 'hE0) * 8 + b];
        end
        if (a == 8'hE3) r[7] = m_swp;
        return r;
    endfunction

    task automatic compare();
        logic       e_req = 0;
        logic [4:0] e_vec = '0;
        logic [7:0] e_rd;
        for (int i = 23; i >= 0; i--)
            if (m_flag[i] && m_ena[i]) begin e_req = 1; e_vec = 5'(i); end
        e_rd = model_read(addr);
        n_chk++;
        if (req !== e_req || vec !== e_vec || rdata !== e_rd) begin
            n_bad++;
            $display("FAIL %s cycle %0d: req/vec/rdata got %b/%0d/%h expected %b/%0d/%h",
                     tag, cyc, req, vec, rdata, e_req, e_vec, e_rd);
        end
    endtask

    // One clock: step model, wait an edge, compare, drop pulses.
    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        cyc++;
        compare();
        evt = '0; we = 0; ack = 0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        addr = a; wdata = d; we = 1; tick();
    endtask

    task automatic rd(input logic [7:0] a);
        addr = a; tick();
    endtask

    // Watchdog: counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        tag = "R10"; rst_n = 0; tick(); tick(); rst_n = 1;
        rd(8'hDA); rd(8'hE0); rd(8'hE3); rd(8'h55);        // R10 reset and unmapped
        tag = "R2"; evt = 24'h000020; addr = 8'hDA; tick(); // R2 masked event still posts
        tag = "R3"; rd(8'hDA);                              // R3 no request while masked
        tag = "R4"; wr(8'hE0, 8'h20); rd(8'hE0);            // R4 enable read-back, R3 request
        tag = "R8"; wr(8'hE2, 8'hFF); wr(8'hE1, 8'h02);
        evt = 24'h820008; addr = 8'hDC; tick();             // R8 sources 3,17,23 posted
        rd(8'hDB); rd(8'hDA);                               // R1 readback per group
        tag = "R9"; ack = 1; ack_vec = 5'd5; tick();        // R9 only source 5 cleared
        ack = 1; ack_vec = 5'd17; tick();                   // R9 next winner 23
        tag = "R5"; addr = 8'hDA; wr(8'hDA, 8'hFF);         // R5 ones do nothing
        wr(8'hDA, 8'hF7); rd(8'hDA);                        // R5 zero clears source 3
        tag = "R4"; wr(8'hE3, 8'h7F); rd(8'hE3);            // R4 low control bits read 0
        wr(8'hE3, 8'h80); rd(8'hE3);
        tag = "R6"; wr(8'hDB, 8'h00); rd(8'hDC);            // R6 zeros ignored
        wr(8'hDB, 8'h06); rd(8'hDB);                        // R6 ones post 9 and 10
        tag = "R7"; wr(8'hE3, 8'h00);
        evt = 24'h000400; wr(8'hDB, 8'h00); rd(8'hDB);      // R7 event beats register clear
        evt = 24'h800000; ack = 1; ack_vec = 5'd23; tick(); // R7 event beats acknowledge
        rd(8'hDC);
        tag = "R3"; wr(8'hE2, 8'h00); rd(8'hDC);            // R3 posted but disabled
        tag = "R1"; wr(8'hDC, 8'h00); wr(8'hDB, 8'h00); rd(8'hDB); rd(8'hDC);
        tag = "R10"; rst_n = 0; tick(); rst_n = 1; rd(8'hE1); rd(8'hE3);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule